// File: doc/BRIEF.md
# Two-World Memory Access Guard

This block sits on a memory bus and decides, for every access, whether it may proceed. Each request carries a non-secure flag: a request with the flag clear belongs to the secure world, one with the flag set belongs to the normal world. The block cannot change the world of a request; it only reads the flag. The address space is divided into a parameterised number of regions. Each region is an inclusive address window with two independent 2-bit permission fields, one for each world. The same block can guard on-chip RAM or main memory by giving it the regions for that range.

The decision is combinational. A grant or a fault is returned in the same cycle as the request, and the request channel never applies back-pressure. A denied access is captured in a fault record that keeps its contents until software clears it. Region settings are written through a separate configuration port. Only secure-world writes change them. A normal-world write is dropped and logged as a fault.

Top module: `world_access_guard`

## Requirements
- R1: Permission fields hold 2 bits per world: 00 no access, 01 read-only, 10 write-only, 11 read-write (bit 0 allows reads, bit 1 allows writes). A request with req_ns=0 is checked against the secure field, which is perm bits [1:0]. A request with req_ns=1 is checked against the normal field, which is perm bits [3:2].
- R2: req_ready is always 1. rsp_valid equals req_valid in the same cycle. While rsp_valid is high, exactly one of rsp_grant and rsp_fault is high. Both are low when there is no request.
- R3: Where regions overlap, the lowest-numbered matching region alone decides the outcome.
- R4: A region matches when base <= address <= limit, with both bounds inclusive. After reset every region has base all ones, limit 0 and perm 0000, so it matches nothing.
- R5: An address that matches no region is granted to secure requests and faulted for normal requests, for reads and writes alike.
- R6: When the record is empty, a faulted request stores its address, direction and flag in the record, with flt_cfg=0. A full record keeps its contents through later faults until flt_clear. A fault in the same cycle as flt_clear is stored.
- R7: A configuration write with cfg_ns=1 changes no region. When the record can load, it stores flt_cfg=1, flt_addr = the region index, flt_write=1 and flt_ns=1.
- R8: A secure configuration write takes effect from the cycle after it is presented. A request in the same cycle is judged with the old settings.
- R9: After reset the fault record is empty (flt_valid=0).
- R10: If a bus fault and a rejected configuration write occur in the same cycle, the bus fault is the one stored.
- R11: Configuration field codes are 0 base, 1 limit, 2 permissions (cfg_wdata[3:0]) and 3 reserved. A secure write to the reserved code changes nothing and logs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Always high: requests are never stalled |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ns | input | 1 | Non-secure flag: 1 normal world, 0 secure world |
| rsp_valid | output | 1 | Decision present, same cycle as request |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied (error response) |
| cfg_valid | input | 1 | Configuration write present |
| cfg_ready | output | 1 | Always high |
| cfg_ns | input | 1 | World of the configuration write |
| cfg_idx | input | IDX_W | Region index |
| cfg_field | input | 2 | 0 base, 1 limit, 2 perm, 3 reserved |
| cfg_wdata | input | ADDR_W | Write data |
| flt_clear | input | 1 | Empties the fault record |
| flt_valid | output | 1 | Fault record holds an entry |
| flt_cfg | output | 1 | Entry came from a rejected configuration write |
| flt_addr | output | ADDR_W | Faulting address, or region index for configuration faults |
| flt_write | output | 1 | Direction of the faulting access |
| flt_ns | output | 1 | Flag of the faulting access |

## Verification
The bench builds the block with ADDR_W=16 and NREG=4. The narrow addresses keep the window edges short and readable. Four regions are enough for overlapping windows, an unused region that must stay inert, and writes to the highest index. Together these reach the priority order, the inclusive bounds on both sides and the unmatched-address default. The bench also drives timing collisions: a configuration write in the same cycle as a request, a clear in the same cycle as a new fault, and a bus fault together with a rejected configuration write.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_PERM  = 2'd2,
    FLD_RSVD  = 2'd3
  } cfg_field_e;

  // bit 0 allows reads, bit 1 allows writes
  typedef struct packed {
    logic wr;
    logic rd;
  } perm_t;

  // [3:2] normal world, [1:0] secure world
  typedef struct packed {
    perm_t nrm;
    perm_t sec;
  } region_perm_t;
endpackage

// File: rtl/wag_region.sv
module wag_region
  import wag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] probe_addr,
  output logic         hit,
  output region_perm_t perm
);
  logic [AW-1:0] base_q, limit_q;
  region_perm_t  perm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '1;
      limit_q <= '0;
      perm_q  <= '0;
    end else if (wr_en) begin
      unique case (cfg_field_e'(wr_field))
        FLD_BASE:  base_q  <= wr_data;
        FLD_LIMIT: limit_q <= wr_data;
        FLD_PERM:  perm_q  <= region_perm_t'(wr_data[3:0]);
        default:   ;
      endcase
    end
  end

  assign hit  = (probe_addr >= base_q) && (probe_addr <= limit_q);
  assign perm = perm_q;
endmodule

// File: rtl/wag_pick.sv
module wag_pick
  import wag_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]         hit,
  input  region_perm_t [NREG-1:0] perm_a,
  output logic                    any_hit,
  output region_perm_t            perm_sel
);
  always_comb begin
    any_hit  = 1'b0;
    perm_sel = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit  = 1'b1;
        perm_sel = perm_a[i];
      end
    end
  end
endmodule

// File: rtl/wag_fault_rec.sv
module wag_fault_rec #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bus_flt,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic          bus_ns,
  input  logic          cfg_flt,
  input  logic [AW-1:0] cfg_tag,
  output logic          valid,
  output logic          is_cfg,
  output logic [AW-1:0] addr,
  output logic          write,
  output logic          ns
);
  logic can_load;
  assign can_load = !valid || clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      is_cfg <= 1'b0;
      addr   <= '0;
      write  <= 1'b0;
      ns     <= 1'b0;
    end else if (can_load) begin
      if (bus_flt) begin
        valid  <= 1'b1;
        is_cfg <= 1'b0;
        addr   <= bus_addr;
        write  <= bus_write;
        ns     <= bus_ns;
      end else if (cfg_flt) begin
        valid  <= 1'b1;
        is_cfg <= 1'b1;
        addr   <= cfg_tag;
        write  <= 1'b1;
        ns     <= 1'b1;
      end else if (clear) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/world_access_guard.sv
module world_access_guard
  import wag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_ns,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_fault,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_ns,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              flt_clear,
  output logic              flt_valid,
  output logic              flt_cfg,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_write,
  output logic              flt_ns
);
  logic [NREG-1:0]         hit;
  region_perm_t [NREG-1:0] perm_a;
  logic                    any_hit;
  region_perm_t            perm_sel;
  perm_t                   world_perm;
  logic                    allowed;
  logic                    cfg_reject;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic we;
    assign we = cfg_valid && !cfg_ns && (cfg_idx == IDX_W'(g));
    wag_region #(.AW(ADDR_W)) u_region (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (we),
      .wr_field   (cfg_field),
      .wr_data    (cfg_wdata),
      .probe_addr (req_addr),
      .hit        (hit[g]),
      .perm       (perm_a[g])
    );
  end

  wag_pick #(.NREG(NREG)) u_pick (
    .hit      (hit),
    .perm_a   (perm_a),
    .any_hit  (any_hit),
    .perm_sel (perm_sel)
  );

  assign world_perm = req_ns ? perm_sel.nrm : perm_sel.sec;
  assign allowed    = any_hit ? (req_write ? world_perm.wr : world_perm.rd) : !req_ns;

  assign req_ready  = 1'b1;
  assign cfg_ready  = 1'b1;
  assign rsp_valid  = req_valid;
  assign rsp_grant  = req_valid && allowed;
  assign rsp_fault  = req_valid && !allowed;
  assign cfg_reject = cfg_valid && cfg_ns;

  wag_fault_rec #(.AW(ADDR_W)) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flt_clear),
    .bus_flt   (rsp_fault),
    .bus_addr  (req_addr),
    .bus_write (req_write),
    .bus_ns    (req_ns),
    .cfg_flt   (cfg_reject),
    .cfg_tag   (ADDR_W'(cfg_idx)),
    .valid     (flt_valid),
    .is_cfg    (flt_cfg),
    .addr      (flt_addr),
    .write     (flt_write),
    .ns        (flt_ns)
  );
endmodule

// File: rtl/wag_checker.sv
module wag_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic          req_ns,
  input logic          rsp_valid,
  input logic          rsp_grant,
  input logic          rsp_fault,
  input logic          cfg_valid,
  input logic          cfg_ns,
  input logic          flt_clear,
  input logic          flt_valid,
  input logic          flt_cfg,
  input logic [AW-1:0] flt_addr,
  input logic          flt_write,
  input logic          flt_ns
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant ^ rsp_fault)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_grant && !rsp_fault)); // R2

  AST_FLT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && (!flt_valid || flt_clear)) |=>
      (flt_valid && !flt_cfg && flt_addr == $past(req_addr) &&
       flt_write == $past(req_write) && flt_ns == $past(req_ns))); // R6

  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clear) |=>
      (flt_valid && $stable(flt_addr) && $stable(flt_cfg) &&
       $stable(flt_write) && $stable(flt_ns))); // R6

  AST_CFG_NS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ns && !rsp_fault && (!flt_valid || flt_clear)) |=>
      (flt_valid && flt_cfg && flt_write && flt_ns)); // R7

  AST_BUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ns && rsp_fault && (!flt_valid || flt_clear)) |=>
      !flt_cfg); // R10
endmodule

bind world_access_guard wag_checker #(.AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_write (req_write),
  .req_ns    (req_ns),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_fault (rsp_fault),
  .cfg_valid (cfg_valid),
  .cfg_ns    (cfg_ns),
  .flt_clear (flt_clear),
  .flt_valid (flt_valid),
  .flt_cfg   (flt_cfg),
  .flt_addr  (flt_addr),
  .flt_write (flt_write),
  .flt_ns    (flt_ns)
);

// File: tb/world_access_guard_bench.sv
module world_access_guard_bench;
  localparam int AW = 16;
  localparam int NR = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic cfg_valid = 1'b0, cfg_ns = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0] cfg_field = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic flt_clear = 1'b0;
  logic req_ready, rsp_valid, rsp_grant, rsp_fault, cfg_ready;
  logic flt_valid, flt_cfg, flt_write, flt_ns;
  logic [AW-1:0] flt_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  world_access_guard #(.ADDR_W(AW), .NREG(NR)) u_world_access_guard (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_ns(req_ns),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_ns(cfg_ns),
    .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .flt_clear(flt_clear), .flt_valid(flt_valid), .flt_cfg(flt_cfg),
    .flt_addr(flt_addr), .flt_write(flt_write), .flt_ns(flt_ns)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic ns, int idx, int fld, logic [AW-1:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ns = ns; cfg_idx = IW'(idx);
    cfg_field = 2'(fld); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_valid = 1'b0; cfg_ns = 1'b0;
  endtask

  task automatic clear_rec();
    @(negedge clk); flt_clear = 1'b1;
    @(posedge clk); #1; flt_clear = 1'b0;
  endtask

  // drive one request; check the combinational decision, then let it register
  task automatic access(string tag, logic [AW-1:0] a, logic wr, logic ns, logic exp_grant);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_ns = ns;
    #1;
    chk({tag, " grant"}, 32'(rsp_grant), 32'(exp_grant));
    chk({tag, " fault"}, 32'(rsp_fault), 32'(!exp_grant));
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 empty record", 32'(flt_valid), 32'd0);
    chk("R2 ready", 32'(req_ready), 32'd1);
    @(negedge clk); #1;
    chk("R2 idle grant", 32'(rsp_grant), 32'd0);
    chk("R2 idle fault", 32'(rsp_fault), 32'd0);
    access("R4 R5 reset secure", 16'h1234, 1'b1, 1'b0, 1'b1);
    access("R4 R5 reset normal", 16'h1234, 1'b0, 1'b1, 1'b0);
    clear_rec();
  endtask

  task automatic t_setup();
    cfg_wr(1'b0, 0, 0, 16'h1000); cfg_wr(1'b0, 0, 1, 16'h1FFF); cfg_wr(1'b0, 0, 2, 16'h0003);
    cfg_wr(1'b0, 1, 0, 16'h1800); cfg_wr(1'b0, 1, 1, 16'h2FFF); cfg_wr(1'b0, 1, 2, 16'h000D);
    cfg_wr(1'b0, 3, 0, 16'h4000); cfg_wr(1'b0, 3, 1, 16'h40FF); cfg_wr(1'b0, 3, 2, 16'h0006);
  endtask

  task automatic t_perm();
    access("R1 sec read WO", 16'h4010, 1'b0, 1'b0, 1'b0);
    access("R1 sec write WO", 16'h4010, 1'b1, 1'b0, 1'b1);
    access("R1 nrm read RO", 16'h4010, 1'b0, 1'b1, 1'b1);
    access("R1 nrm write RO", 16'h4010, 1'b1, 1'b1, 1'b0);
    access("R1 nrm write RW", 16'h2000, 1'b1, 1'b1, 1'b1);
    access("R1 sec write RO", 16'h2000, 1'b1, 1'b0, 1'b0);
    access("R1 nrm none", 16'h1100, 1'b0, 1'b1, 1'b0);
    clear_rec();
  endtask

  task automatic t_prio();
    access("R3 overlap nrm read", 16'h1900, 1'b0, 1'b1, 1'b0);
    access("R3 overlap sec write", 16'h1900, 1'b1, 1'b0, 1'b1);
    clear_rec();
  endtask

  task automatic t_bounds();
    access("R4 limit edge", 16'h2FFF, 1'b0, 1'b1, 1'b1);
    access("R4 past limit", 16'h3000, 1'b0, 1'b1, 1'b0);
    access("R4 base edge", 16'h1000, 1'b1, 1'b0, 1'b1);
    access("R4 below base", 16'h0FFF, 1'b0, 1'b1, 1'b0);
    access("R5 unmatched sec", 16'h0FFF, 1'b0, 1'b0, 1'b1);
    clear_rec();
  endtask

  task automatic t_record();
    chk("R6 cleared", 32'(flt_valid), 32'd0);
    access("R6 first fault", 16'h4020, 1'b1, 1'b1, 1'b0);
    chk("R6 valid", 32'(flt_valid), 32'd1);
    chk("R6 addr", 32'(flt_addr), 32'h4020);
    chk("R6 write", 32'(flt_write), 32'd1);
    chk("R6 ns", 32'(flt_ns), 32'd1);
    chk("R6 cfg", 32'(flt_cfg), 32'd0);
    access("R6 second fault", 16'h0000, 1'b0, 1'b1, 1'b0);
    chk("R6 hold addr", 32'(flt_addr), 32'h4020);
    chk("R6 hold write", 32'(flt_write), 32'd1);
    clear_rec();
    chk("R6 clear", 32'(flt_valid), 32'd0);
    access("R6 seed", 16'h4020, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    flt_clear = 1'b1;
    req_valid = 1'b1; req_addr = 16'h0055; req_write = 1'b0; req_ns = 1'b1;
    @(posedge clk); #1;
    flt_clear = 1'b0; req_valid = 1'b0;
    chk("R6 clear+fault valid", 32'(flt_valid), 32'd1);
    chk("R6 clear+fault addr", 32'(flt_addr), 32'h0055);
    chk("R6 clear+fault write", 32'(flt_write), 32'd0);
    clear_rec();
  endtask

  task automatic t_cfg_ns();
    cfg_wr(1'b1, 0, 2, 16'h000F);
    chk("R7 logged", 32'(flt_valid), 32'd1);
    chk("R7 cfg flag", 32'(flt_cfg), 32'd1);
    chk("R7 index", 32'(flt_addr), 32'd0);
    chk("R7 ns", 32'(flt_ns), 32'd1);
    chk("R7 write", 32'(flt_write), 32'd1);
    clear_rec();
    access("R7 perm unchanged", 16'h1100, 1'b0, 1'b1, 1'b0);
    clear_rec();
    cfg_wr(1'b1, 3, 0, 16'h0000);
    chk("R7 index3", 32'(flt_addr), 32'd3);
    clear_rec();
    access("R7 base unchanged", 16'h0010, 1'b0, 1'b0, 1'b1);
    access("R7 base unchanged nrm", 16'h0010, 1'b0, 1'b1, 1'b0);
    clear_rec();
    cfg_wr(1'b0, 2, 3, 16'hFFFF);
    chk("R11 reserved no log", 32'(flt_valid), 32'd0);
    access("R11 reserved no effect", 16'h3000, 1'b0, 1'b1, 1'b0);
    clear_rec();
  endtask

  task automatic t_timing();
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ns = 1'b0; cfg_idx = 2'd0; cfg_field = 2'd2; cfg_wdata = 16'h000F;
    req_valid = 1'b1; req_addr = 16'h1100; req_write = 1'b0; req_ns = 1'b1;
    #1;
    chk("R8 same cycle old", 32'(rsp_fault), 32'd1);
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    chk("R8 next cycle new", 32'(rsp_grant), 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    cfg_wr(1'b0, 0, 2, 16'h0003);
    clear_rec();
  endtask

  task automatic t_both();
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ns = 1'b1; cfg_idx = 2'd2; cfg_field = 2'd0; cfg_wdata = 16'h0;
    req_valid = 1'b1; req_addr = 16'h0000; req_write = 1'b0; req_ns = 1'b1;
    @(posedge clk); #1;
    cfg_valid = 1'b0; req_valid = 1'b0;
    chk("R10 valid", 32'(flt_valid), 32'd1);
    chk("R10 bus wins", 32'(flt_cfg), 32'd0);
    chk("R10 addr", 32'(flt_addr), 32'h0000);
    clear_rec();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_setup();
    t_perm();
    t_prio();
    t_bounds();
    t_record();
    t_cfg_ns();
    t_timing();
    t_both();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule